// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the raster timing for a TFT display panel. A programmable divider turns the bus clock into a pixel-rate enable and a matching pixel clock waveform. Two phase counters are built from one shared counter design. One counter walks each line through sync, back porch, active and front porch, one pixel at a time. The other walks the frame through the same four phases, one line at a time. From these counters the block drives horizontal sync, vertical sync, a data-enable strobe and an optional end-of-line pulse. Each of these four outputs has its own polarity inversion.

Every timing value is a static configuration input. Each duration field holds its length minus one. The block also reports which phase each axis is in, the position of the current pixel inside the visible area, and a count of visible lines remaining that runs downward. A single enable input starts the timing. Clearing the enable returns everything to the start of vertical sync and forces all strobes to their idle levels.

Top module: `tft_timing_gen`

## Requirements
- R1: With the divider input D taken as max(D,1), `pix_tick_o` is high for exactly one bus cycle in every 2×(D+1). The first tick falls in bus cycle 2×D+1 after enable, where the cycle in which enable is first high is cycle 0.
- R2: `pclk_o` has the same period as the tick. Its internal half-phase is low for the first D+1 cycles of each pixel period and high for the last D+1. With `cfg_sample_rise`=1, `pclk_o` equals that half-phase, so it rises in the middle of the pixel. With `cfg_sample_rise`=0 it is the inverse.
- R3: The horizontal phase code `h_phase_o` uses 00 sync, 01 back porch, 10 active and 11 front porch. Each pixel tick advances it by one pixel. Each phase lasts its field value plus one pixels, and after front porch the code returns to sync.
- R4: The vertical phase code `v_phase_o` uses the same encoding. It advances once per line, at the tick that ends a horizontal front porch, and each phase lasts its field value plus one lines.
- R5: `hsync_o` is high exactly while the horizontal code is 00, and `vsync_o` exactly while the vertical code is 00. Each is XORed with its own invert input.
- R6: `de_o` is high exactly when both codes are 10, XORed with `cfg_inv_de`.
- R7: `lend_o` is high during the last pixel of each line's front porch, but only when `cfg_lend_en`=1. It is XORed with `cfg_inv_lend`, so with the enable bit at 0 it stays at the inverted idle level.
- R8: `line_left_o` equals the active-height field minus the row index during vertical active. It reads 0 in vertical front porch, and it reads the active-height field in vertical sync and back porch.
- R9: `pix_x_o` and `pix_y_o` give the column and row inside the visible area while the matching axis is active, and 0 otherwise.
- R10: While `en_i`=0, no tick occurs and every strobe sits at its idle level (the value of its invert input). From the second disabled cycle onward both phase codes read 00. After enable returns, timing restarts from the first pixel of vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Timing and video output enable |
| cfg_div | input | 10 | Pixel clock divider value D |
| cfg_hsync_w | input | 8 | Horizontal sync length minus one |
| cfg_hback | input | 7 | Horizontal back porch length minus one |
| cfg_hactive | input | 11 | Visible width minus one |
| cfg_hfront | input | 8 | Horizontal front porch length minus one |
| cfg_vsync_w | input | 6 | Vertical sync length minus one, in lines |
| cfg_vback | input | 8 | Vertical back porch length minus one |
| cfg_vactive | input | 10 | Visible height minus one |
| cfg_vfront | input | 8 | Vertical front porch length minus one |
| cfg_lend_en | input | 1 | Enables the end-of-line pulse |
| cfg_inv_hsync | input | 1 | Inverts horizontal sync |
| cfg_inv_vsync | input | 1 | Inverts vertical sync |
| cfg_inv_de | input | 1 | Inverts data enable |
| cfg_inv_lend | input | 1 | Inverts end-of-line pulse |
| cfg_sample_rise | input | 1 | 1: data sampled on pixel clock rising edge |
| pix_tick_o | output | 1 | One-cycle pixel-rate enable |
| pclk_o | output | 1 | Pixel clock waveform |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| lend_o | output | 1 | End-of-line pulse |
| h_phase_o | output | 2 | Horizontal phase code |
| v_phase_o | output | 2 | Vertical phase code |
| line_left_o | output | 10 | Down-counting visible line counter |
| pix_x_o | output | 11 | Visible column |
| pix_y_o | output | 10 | Visible row |

## Verification
Both phase codes and both position outputs are driven straight from the counter state. A counter that has slipped by one pixel or one line therefore shows at the ports in the same bus cycle, and the bench compares these outputs with an arithmetic model every bus cycle. A divider that is off by one shows within a single pixel period, as a tick in the wrong cycle or a `pclk_o` level in the wrong half. A wrong vertical step is visible by the next line boundary. The bench sweeps whole frames of small geometries under several divider, polarity and line-end settings, and also drops the enable partway through a frame.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'b00,
    PH_BACK  = 2'b01,
    PH_ACT   = 2'b10,
    PH_FRONT = 2'b11
  } phase_e;

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_SYNC:  return PH_BACK;
      PH_BACK:  return PH_ACT;
      PH_ACT:   return PH_FRONT;
      default:  return PH_SYNC;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    return max2(max2(a, b), max2(c, d));
  endfunction

endpackage

// File: rtl/tft_pix_div.sv
module tft_pix_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rise_i,
  output logic             tick_o,
  output logic             pclk_o
);

  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1);

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v < DIV_MIN) ? DIV_MIN : v;
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             half_q;
  logic             wrap;

  assign lim  = eff_div(div_i);
  assign wrap = (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i & half_q & wrap;
  assign pclk_o = rise_i ? half_q : ~half_q;

endmodule

// File: rtl/tft_axis.sv
module tft_axis
  import tft_timing_pkg::*;
#(
  parameter int SYNC_W  = 8,
  parameter int BACK_W  = 7,
  parameter int ACT_W   = 11,
  parameter int FRONT_W = 8,
  parameter int CNT_W   = max4(SYNC_W, BACK_W, ACT_W, FRONT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               step_i,
  input  logic [SYNC_W-1:0]  sync_len_i,
  input  logic [BACK_W-1:0]  back_len_i,
  input  logic [ACT_W-1:0]   act_len_i,
  input  logic [FRONT_W-1:0] front_len_i,
  output phase_e             phase_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               last_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] seg_end;
  logic             seg_done;

  always_comb begin
    case (phase_q)
      PH_SYNC:  seg_end = CNT_W'(sync_len_i);
      PH_BACK:  seg_end = CNT_W'(back_len_i);
      PH_ACT:   seg_end = CNT_W'(act_len_i);
      default:  seg_end = CNT_W'(front_len_i);
    endcase
  end

  assign seg_done = (cnt_q >= seg_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (step_i) begin
      if (seg_done) begin
        phase_q <= phase_after(phase_q);
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign last_o  = (phase_q == PH_FRONT) && seg_done;

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_timing_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int HSW_W  = 8,
  parameter int HBP_W  = 7,
  parameter int HACT_W = 11,
  parameter int HFP_W  = 8,
  parameter int VSW_W  = 6,
  parameter int VBP_W  = 8,
  parameter int VACT_W = 10,
  parameter int VFP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HSW_W-1:0]  cfg_hsync_w,
  input  logic [HBP_W-1:0]  cfg_hback,
  input  logic [HACT_W-1:0] cfg_hactive,
  input  logic [HFP_W-1:0]  cfg_hfront,
  input  logic [VSW_W-1:0]  cfg_vsync_w,
  input  logic [VBP_W-1:0]  cfg_vback,
  input  logic [VACT_W-1:0] cfg_vactive,
  input  logic [VFP_W-1:0]  cfg_vfront,
  input  logic              cfg_lend_en,
  input  logic              cfg_inv_hsync,
  input  logic              cfg_inv_vsync,
  input  logic              cfg_inv_de,
  input  logic              cfg_inv_lend,
  input  logic              cfg_sample_rise,
  output logic              pix_tick_o,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              lend_o,
  output logic [1:0]        h_phase_o,
  output logic [1:0]        v_phase_o,
  output logic [VACT_W-1:0] line_left_o,
  output logic [HACT_W-1:0] pix_x_o,
  output logic [VACT_W-1:0] pix_y_o
);

  localparam int HCNT_W = max4(HSW_W, HBP_W, HACT_W, HFP_W);
  localparam int VCNT_W = max4(VSW_W, VBP_W, VACT_W, VFP_W);

  // named internal events, observed by the bound checker
  logic              pix_tick;
  logic              line_done;
  logic              h_last;
  logic              v_last;
  phase_e            h_phase;
  phase_e            v_phase;
  logic [HCNT_W-1:0] h_cnt;
  logic [VCNT_W-1:0] v_cnt;
  logic              h_act;
  logic              v_act;

  tft_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .div_i  (cfg_div),
    .rise_i (cfg_sample_rise),
    .tick_o (pix_tick),
    .pclk_o (pclk_o)
  );

  tft_axis #(
    .SYNC_W (HSW_W), .BACK_W (HBP_W), .ACT_W (HACT_W), .FRONT_W (HFP_W), .CNT_W (HCNT_W)
  ) u_hax (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .step_i      (pix_tick),
    .sync_len_i  (cfg_hsync_w),
    .back_len_i  (cfg_hback),
    .act_len_i   (cfg_hactive),
    .front_len_i (cfg_hfront),
    .phase_o     (h_phase),
    .cnt_o       (h_cnt),
    .last_o      (h_last)
  );

  assign line_done = pix_tick & h_last;

  tft_axis #(
    .SYNC_W (VSW_W), .BACK_W (VBP_W), .ACT_W (VACT_W), .FRONT_W (VFP_W), .CNT_W (VCNT_W)
  ) u_vax (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .step_i      (line_done),
    .sync_len_i  (cfg_vsync_w),
    .back_len_i  (cfg_vback),
    .act_len_i   (cfg_vactive),
    .front_len_i (cfg_vfront),
    .phase_o     (v_phase),
    .cnt_o       (v_cnt),
    .last_o      (v_last)
  );

  function automatic logic [VACT_W-1:0] lines_remaining(
    input phase_e ph, input logic [VACT_W-1:0] height, input logic [VACT_W-1:0] row);
    case (ph)
      PH_ACT:   return height - row;
      PH_FRONT: return '0;
      default:  return height;
    endcase
  endfunction

  assign h_act = (h_phase == PH_ACT);
  assign v_act = (v_phase == PH_ACT);

  assign pix_tick_o  = pix_tick;
  assign h_phase_o   = h_phase;
  assign v_phase_o   = v_phase;
  assign hsync_o     = (en_i & (h_phase == PH_SYNC)) ^ cfg_inv_hsync;
  assign vsync_o     = (en_i & (v_phase == PH_SYNC)) ^ cfg_inv_vsync;
  assign de_o        = (en_i & h_act & v_act) ^ cfg_inv_de;
  assign lend_o      = (en_i & cfg_lend_en & h_last) ^ cfg_inv_lend;
  assign line_left_o = lines_remaining(v_phase, cfg_vactive, v_cnt[VACT_W-1:0]);
  assign pix_x_o     = h_act ? h_cnt[HACT_W-1:0] : '0;
  assign pix_y_o     = v_act ? v_cnt[VACT_W-1:0] : '0;

endmodule

// File: rtl/tft_timing_chk.sv
module tft_timing_chk #(
  parameter int VACT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              pix_tick_o,
  input logic              line_done,
  input logic [1:0]        h_phase_o,
  input logic [1:0]        v_phase_o,
  input logic              de_o,
  input logic              lend_o,
  input logic              cfg_inv_de,
  input logic              cfg_inv_lend,
  input logic [VACT_W-1:0] cfg_vactive,
  input logic [VACT_W-1:0] line_left_o
);

  AST_HPHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && (h_phase_o != $past(h_phase_o)))
      |-> (h_phase_o == 2'($past(h_phase_o) + 2'd1))); // R3

  AST_HPHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && (h_phase_o != $past(h_phase_o))) |-> $past(pix_tick_o)); // R3

  AST_VPHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && (v_phase_o != $past(v_phase_o)))
      |-> ((v_phase_o == 2'($past(v_phase_o) + 2'd1)) && $past(line_done))); // R4

  AST_DE_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o != cfg_inv_de) |-> ((h_phase_o == 2'b10) && (v_phase_o == 2'b10))); // R6

  AST_LEND_IN_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    (lend_o != cfg_inv_lend) |-> (h_phase_o == 2'b11)); // R7

  AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    line_left_o <= cfg_vactive); // R8

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !$past(en_i)) |-> (!pix_tick_o && (h_phase_o == 2'b00) && (v_phase_o == 2'b00))); // R10

endmodule

bind tft_timing_gen tft_timing_chk #(.VACT_W(VACT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .pix_tick_o   (pix_tick_o),
  .line_done    (line_done),
  .h_phase_o    (h_phase_o),
  .v_phase_o    (v_phase_o),
  .de_o         (de_o),
  .lend_o       (lend_o),
  .cfg_inv_de   (cfg_inv_de),
  .cfg_inv_lend (cfg_inv_lend),
  .cfg_vactive  (cfg_vactive),
  .line_left_o  (line_left_o)
);

// File: tb/tft_timing_gen_test.sv
`timescale 1ns/1ps
module tft_timing_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [9:0]  cfg_div = '0;
  logic [7:0]  cfg_hsync_w = '0;
  logic [6:0]  cfg_hback = '0;
  logic [10:0] cfg_hactive = '0;
  logic [7:0]  cfg_hfront = '0;
  logic [5:0]  cfg_vsync_w = '0;
  logic [7:0]  cfg_vback = '0;
  logic [9:0]  cfg_vactive = '0;
  logic [7:0]  cfg_vfront = '0;
  logic        cfg_lend_en = 1'b0, cfg_inv_hsync = 1'b0, cfg_inv_vsync = 1'b0;
  logic        cfg_inv_de = 1'b0, cfg_inv_lend = 1'b0, cfg_sample_rise = 1'b0;
  logic        pix_tick_o, pclk_o, hsync_o, vsync_o, de_o, lend_o;
  logic [1:0]  h_phase_o, v_phase_o;
  logic [9:0]  line_left_o;
  logic [10:0] pix_x_o;
  logic [9:0]  pix_y_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tft_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .cfg_div(cfg_div),
    .cfg_hsync_w(cfg_hsync_w), .cfg_hback(cfg_hback), .cfg_hactive(cfg_hactive),
    .cfg_hfront(cfg_hfront), .cfg_vsync_w(cfg_vsync_w), .cfg_vback(cfg_vback),
    .cfg_vactive(cfg_vactive), .cfg_vfront(cfg_vfront), .cfg_lend_en(cfg_lend_en),
    .cfg_inv_hsync(cfg_inv_hsync), .cfg_inv_vsync(cfg_inv_vsync), .cfg_inv_de(cfg_inv_de),
    .cfg_inv_lend(cfg_inv_lend), .cfg_sample_rise(cfg_sample_rise),
    .pix_tick_o(pix_tick_o), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .lend_o(lend_o), .h_phase_o(h_phase_o), .v_phase_o(v_phase_o),
    .line_left_o(line_left_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
  );

  task automatic chk(input string rq, input int act, input int exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp_v, $time);
    end
  endtask

  // split an index along an axis of four segments with lengths a,b,c,d
  task automatic seg(input int idx, input int a, input int b, input int c,
                     output int ph, output int off);
    if (idx < a)              begin ph = 0; off = idx;         end
    else if (idx < a + b)     begin ph = 1; off = idx - a;     end
    else if (idx < a + b + c) begin ph = 2; off = idx - a - b; end
    else                      begin ph = 3; off = idx - a - b - c; end
  endtask

  task automatic check_idle(input bit full);
    chk("R10 tick idle", int'(pix_tick_o), 0);
    chk("R10 hsync idle", int'(hsync_o), int'(cfg_inv_hsync));
    chk("R10 vsync idle", int'(vsync_o), int'(cfg_inv_vsync));
    chk("R10 de idle", int'(de_o), int'(cfg_inv_de));
    chk("R10 lend idle", int'(lend_o), int'(cfg_inv_lend));
    if (full) begin
      chk("R10 hphase idle", int'(h_phase_o), 0);
      chk("R10 vphase idle", int'(v_phase_o), 0);
      chk("R10 line_left idle", int'(line_left_o), int'(cfg_vactive));
    end
  endtask

  task automatic run_cfg(input int dv, input int hs, input int hb, input int ha, input int hf,
                         input int vs, input int vb, input int va, input int vf,
                         input bit ih, input bit iv, input bit ide, input bit ile,
                         input bit len, input bit rise, input int cycles);
    int c, L, F, p, k, q, x, y, hph, hoff, vph, voff, exp_ll;
    cfg_div = 10'(dv); cfg_hsync_w = 8'(hs); cfg_hback = 7'(hb); cfg_hactive = 11'(ha);
    cfg_hfront = 8'(hf); cfg_vsync_w = 6'(vs); cfg_vback = 8'(vb); cfg_vactive = 10'(va);
    cfg_vfront = 8'(vf); cfg_inv_hsync = ih; cfg_inv_vsync = iv; cfg_inv_de = ide;
    cfg_inv_lend = ile; cfg_lend_en = len; cfg_sample_rise = rise;
    @(negedge clk);
    #1 check_idle(1'b1);
    @(negedge clk);
    en_i = 1'b1;
    c = (dv < 1) ? 1 : dv;
    L = hs + hb + ha + hf + 4;
    F = vs + vb + va + vf + 4;
    p = 0; k = 0;
    for (int i = 0; i < cycles; i++) begin
      #1;
      q = p % (L * F);
      x = q % L;
      y = q / L;
      seg(x, hs + 1, hb + 1, ha + 1, hph, hoff);
      seg(y, vs + 1, vb + 1, va + 1, vph, voff);
      exp_ll = (vph == 2) ? (va - voff) : ((vph == 3) ? 0 : va);
      chk("R1 tick", int'(pix_tick_o), (k == 2 * c + 1) ? 1 : 0);
      chk("R2 pclk", int'(pclk_o), ((k >= c + 1) ? 1 : 0) ^ (rise ? 0 : 1));
      chk("R3 hphase", int'(h_phase_o), hph);
      chk("R4 vphase", int'(v_phase_o), vph);
      chk("R5 hsync", int'(hsync_o), ((hph == 0) ? 1 : 0) ^ int'(ih));
      chk("R5 vsync", int'(vsync_o), ((vph == 0) ? 1 : 0) ^ int'(iv));
      chk("R6 de", int'(de_o), ((hph == 2 && vph == 2) ? 1 : 0) ^ int'(ide));
      chk("R7 lend", int'(lend_o), ((len && x == L - 1) ? 1 : 0) ^ int'(ile));
      chk("R8 line_left", int'(line_left_o), exp_ll);
      chk("R9 pix_x", int'(pix_x_o), (hph == 2) ? hoff : 0);
      chk("R9 pix_y", int'(pix_y_o), (vph == 2) ? voff : 0);
      if (pix_tick_o === 1'b1) begin p++; k = 0; end
      else k++;
      @(negedge clk);
    end
    en_i = 1'b0;
    #1 check_idle(1'b0);
    @(negedge clk);
    #1 check_idle(1'b1);
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check_idle(1'b1);      // reset state, R10
    rst_n = 1'b1;
    // R1..R9: divider 1, plain polarity, line end on, rising sample, two frames
    run_cfg(1, 1, 0, 3, 1, 0, 1, 2, 0, 0, 0, 0, 0, 1, 1, 2 * 9 * 7 * 4);
    // R1 clamp of divider 0, every strobe inverted, falling sample
    run_cfg(0, 0, 2, 2, 0, 1, 0, 1, 1, 1, 1, 1, 1, 1, 0, 2 * 8 * 7 * 4);
    // slower divider, line end disabled but inverted (R7 idle level)
    run_cfg(3, 2, 1, 4, 2, 0, 0, 3, 1, 0, 1, 0, 1, 0, 1, 2 * 13 * 8 * 8);
    // R10: drop enable in mid-frame, then restart from vertical sync
    run_cfg(1, 1, 0, 3, 1, 0, 1, 2, 0, 0, 0, 0, 0, 1, 1, 137);
    run_cfg(1, 1, 0, 3, 1, 0, 1, 2, 0, 0, 0, 0, 0, 1, 1, 9 * 7 * 4 + 20);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule